// File: doc/BRIEF.md
# IF Sample Capture-to-USB Streamer

This block accepts a continuous stream of 2-bit digitized intermediate-frequency samples, paced by their own sample clock, and delivers them to an external USB bridge chip as bytes. Four consecutive samples are combined into one byte. This cuts the write rate to a quarter of the sample rate, for example 4.092 MHz bytes from a 16.368 MHz sample stream. The block runs on a single fast system clock (72 MHz in the target). It detects edges of the slow sample clock through a synchronizer and does not run a second clock domain.

Packed bytes go into a circular buffer built from thirteen equal RAM banks. Writes and reads visit the banks in turn, so capture keeps going while older banks drain. A drain engine moves bytes to the bridge through an 8-bit slave-FIFO write port. The endpoint address is fixed, and each write is a single-cycle strobe that is gated by the bridge's active-low full flag. A controller first holds the bridge port idle for an initialization period. It then waits for a start command that carries a byte count, streams exactly that many bytes, and returns to waiting. If the buffer is full when a byte arrives, the byte is lost and a sticky overflow flag is raised.

Top module: `if_capture_streamer`

## Requirements
- R1: After reset, `ready` stays low and `wr_stb` stays low for INIT_CYC clock cycles. `ready` rises on the INIT_CYC-th rising edge after reset is released.
- R2: `start` is ignored unless `ready` is high. A pulse during initialization or during a running acquisition changes neither the state nor the byte count.
- R3: Each byte holds four consecutive samples. The first sample is in bits [1:0], the second in [3:2], the third in [5:4] and the fourth in [7:6].
- R4: Exactly one sample is taken per rising edge of `smp_clk`, and only while an acquisition still needs bytes. Edges seen while idle, and edges after the commanded count has been captured, leave no trace in the output.
- R5: Bytes reach the bridge in capture order. This holds across wrap-around of the ring of NBANK banks of BANK_BYTES bytes each.
- R6: A `wr_stb` pulse is issued only when `full_n` was high in the preceding cycle. While `full_n` is low, writes pause without losing or repeating bytes.
- R7: `wr_stb` lasts one cycle. `fifo_data` holds the same value in the cycle before, the cycle of and the cycle after each pulse.
- R8: `fifo_addr` always presents the endpoint address EP_ADDR, which defaults to 2'b10.
- R9: An acquisition started with length L delivers exactly L bytes. `busy` then falls and `ready` returns. L = 0 returns to ready with no write.
- R10: `ovf` is set when a packed byte arrives while the ring holds NBANK*BANK_BYTES bytes, and that byte is discarded. `ovf` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_clk | input | 1 | Sample clock from the front end, asynchronous to clk |
| smp_data | input | 2 | Sample value, stable around the rising edge of smp_clk |
| start | input | 1 | Start-acquisition command pulse |
| start_len | input | LEN_W | Number of bytes to deliver, taken with start |
| full_n | input | 1 | Bridge FIFO full flag, low when full |
| fifo_data | output | 8 | Byte presented to the bridge |
| fifo_addr | output | 2 | Bridge endpoint select, constant EP_ADDR |
| wr_stb | output | 1 | Single-cycle write strobe |
| ready | output | 1 | Idle and waiting for a command |
| busy | output | 1 | Acquisition in progress |
| ovf | output | 1 | Sticky buffer overflow flag |

## Verification
The embedded assertions watch the bridge handshake on every cycle. They check that no strobe follows a cycle with `full_n` low, that strobes are single pulses with data held on both sides, that the port stays quiet during initialization, that the delivered count never passes the commanded length, and that the overflow flag does not clear by itself. The bench scenarios cover what no single-cycle property can show. These are the bit order inside each byte, the byte order across ring wrap-around under several back-pressure patterns, the exact delivered count, the discarding of stray sample edges, and the set-and-clear life of the overflow flag.

// File: rtl/if_cap_pkg.sv
// Shared state types for the IF capture streamer.
// Assumes: nothing beyond standard SystemVerilog enums.
package if_cap_pkg;

    typedef enum logic [1:0] {
        CS_INIT = 2'd0,
        CS_IDLE = 2'd1,
        CS_RUN  = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_LOAD   = 2'd1,
        WS_SETUP  = 2'd2,
        WS_STROBE = 2'd3
    } wr_state_t;

endpackage

// File: rtl/if_sample_packer.sv
// Samples the slow, asynchronous sample clock and data through a two-flop
// synchronizer, detects rising edges of the sample clock in the fast domain
// and packs four 2-bit samples per byte, first sample in the low bits.
// Assumes: the sample period spans at least four fast clock cycles and the
// data is stable for two fast cycles before each rising sample edge.
module if_sample_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       smp_clk,
    input  logic [1:0] smp_data,
    output logic       byte_vld,
    output logic [7:0] byte_out
);
    logic [2:0] sck_q;
    logic [1:0] sd1_q, sd2_q;
    logic [1:0] phase_q;
    logic [5:0] part_q;
    logic       rise;

    assign rise = sck_q[1] & ~sck_q[2];

    // Synchronize sample clock and data into the fast domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            sd1_q <= '0;
            sd2_q <= '0;
        end else begin
            sck_q <= {sck_q[1:0], smp_clk};
            sd1_q <= smp_data;
            sd2_q <= sd1_q;
        end
    end

    // Collect samples on each detected edge and emit a byte every fourth one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q  <= '0;
            part_q   <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (rise && en) begin
                if (phase_q == 2'd3) begin
                    byte_out <= {sd2_q, part_q};
                    byte_vld <= 1'b1;
                end else begin
                    part_q <= {sd2_q, part_q[5:2]};
                end
                phase_q <= phase_q + 2'd1;
            end
        end
    end

    // R4
    pack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

endmodule

// File: rtl/if_bank_ram.sv
// One buffer bank: simple dual-port RAM with registered read.
// Assumes: the contents are not reset; readers only read written locations.
module if_bank_ram #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/if_bank_ring.sv
// Circular byte buffer made of NBANK banks visited in turn. A write into a
// full ring is discarded and raises a sticky overflow flag.
// Assumes: BANK_BYTES is a power of two of at least 2; pop data appears one
// cycle after the pop.
module if_bank_ring #(
    parameter int NBANK      = 13,
    parameter int BANK_BYTES = 64,
    localparam int OFF_W     = $clog2(BANK_BYTES),
    localparam int BANK_W    = $clog2(NBANK),
    localparam int DEPTH     = NBANK * BANK_BYTES,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       full,
    output logic       ovf
);
    logic [BANK_W-1:0] wbank_q, rbank_q, rsel_q;
    logic [OFF_W-1:0]  woff_q, roff_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept, take;
    logic [7:0]        bank_q [NBANK];

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign rdata  = bank_q[rsel_q];

    // Advance the write and read positions bank by bank and track the fill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wbank_q <= '0;
            woff_q  <= '0;
            rbank_q <= '0;
            roff_q  <= '0;
            rsel_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (accept) begin
                woff_q <= woff_q + OFF_W'(1);
                if (woff_q == OFF_W'(BANK_BYTES - 1))
                    wbank_q <= (wbank_q == BANK_W'(NBANK - 1)) ? '0 : wbank_q + BANK_W'(1);
            end
            if (take) begin
                rsel_q <= rbank_q;
                roff_q <= roff_q + OFF_W'(1);
                if (roff_q == OFF_W'(BANK_BYTES - 1))
                    rbank_q <= (rbank_q == BANK_W'(NBANK - 1)) ? '0 : rbank_q + BANK_W'(1);
            end
            case ({accept, take})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Latch the overflow condition until the next acquisition clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ovf <= 1'b0;
        else if (push && full) ovf <= 1'b1;
    end

    // One RAM per bank, enabled only when its index is selected.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if_bank_ram #(.DEPTH(BANK_BYTES)) u_ram (
            .clk   (clk),
            .we    (accept && (wbank_q == BANK_W'(b))),
            .waddr (woff_q),
            .wdata (wdata),
            .re    (take && (rbank_q == BANK_W'(b))),
            .raddr (roff_q),
            .rdata (bank_q[b])
        );
    end

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R5
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt_q <= CNT_W'(DEPTH)));

endmodule

// File: rtl/if_fifo_writer.sv
// Drains the ring into the bridge slave-FIFO port: reads a byte, puts it on
// the bus, waits for the full flag to be clear, then strobes for one cycle.
// Assumes: full_n is sampled one cycle ahead of the strobe it permits.
module if_fifo_writer
    import if_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       avail,
    input  logic       full_n,
    input  logic [7:0] rdata,
    output logic       pop,
    output logic [7:0] fifo_data,
    output logic       wr_stb
);
    wr_state_t st_q;

    assign pop    = (st_q == WS_IDLE) && en && avail;
    assign wr_stb = (st_q == WS_STROBE);

    // Step through read, bus setup, flag wait and strobe for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= WS_IDLE;
            fifo_data <= '0;
        end else begin
            case (st_q)
                WS_IDLE:   if (pop) st_q <= WS_LOAD;
                WS_LOAD: begin
                    fifo_data <= rdata;
                    st_q      <= WS_SETUP;
                end
                WS_SETUP:  if (full_n) st_q <= WS_STROBE;
                default:   st_q <= WS_IDLE;
            endcase
        end
    end

    // R6
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(full_n));

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $stable(fifo_data));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> $stable(fifo_data));

endmodule

// File: rtl/if_capture_streamer.sv
// Top level: initializes the bridge port, waits for a start command, then
// captures and delivers the commanded number of bytes before returning to
// waiting. Ties together the packer, the bank ring and the FIFO writer.
// Assumes: clk is the fast system clock; smp_clk is much slower.
module if_capture_streamer
    import if_cap_pkg::*;
#(
    parameter int         NBANK      = 13,
    parameter int         BANK_BYTES = 64,
    parameter int         LEN_W      = 24,
    parameter int         INIT_CYC   = 64,
    parameter logic [1:0] EP_ADDR    = 2'b10,
    localparam int        INIT_W     = $clog2(INIT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_clk,
    input  logic [1:0]       smp_data,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             full_n,
    output logic [7:0]       fifo_data,
    output logic [1:0]       fifo_addr,
    output logic             wr_stb,
    output logic             ready,
    output logic             busy,
    output logic             ovf
);
    ctl_state_t        state_q;
    logic [INIT_W-1:0] init_cnt_q;
    logic [LEN_W-1:0]  len_q, pushed_q, sent_q;
    logic              clr, cap_en, byte_vld, ring_full, ring_empty, pop;
    logic [7:0]        byte_out, ring_rdata;

    assign ready     = (state_q == CS_IDLE);
    assign busy      = (state_q == CS_RUN);
    assign clr       = ready && start;
    assign cap_en    = busy && (pushed_q != len_q);
    assign fifo_addr = EP_ADDR;

    // Sequence initialization, command wait and the acquisition run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CS_INIT;
            init_cnt_q <= '0;
            len_q      <= '0;
            pushed_q   <= '0;
            sent_q     <= '0;
        end else begin
            case (state_q)
                CS_INIT: begin
                    init_cnt_q <= init_cnt_q + INIT_W'(1);
                    if (init_cnt_q == INIT_W'(INIT_CYC - 1)) state_q <= CS_IDLE;
                end
                CS_IDLE: if (start) begin
                    len_q    <= start_len;
                    pushed_q <= '0;
                    sent_q   <= '0;
                    state_q  <= CS_RUN;
                end
                default: begin
                    if (byte_vld && !ring_full) pushed_q <= pushed_q + LEN_W'(1);
                    if (wr_stb) sent_q <= sent_q + LEN_W'(1);
                    if (sent_q == len_q) state_q <= CS_IDLE;
                end
            endcase
        end
    end

    if_sample_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (cap_en),
        .smp_clk  (smp_clk),
        .smp_data (smp_data),
        .byte_vld (byte_vld),
        .byte_out (byte_out)
    );

    if_bank_ring #(.NBANK(NBANK), .BANK_BYTES(BANK_BYTES)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (byte_vld),
        .wdata (byte_out),
        .pop   (pop),
        .rdata (ring_rdata),
        .empty (ring_empty),
        .full  (ring_full),
        .ovf   (ovf)
    );

    if_fifo_writer u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .avail     (!ring_empty),
        .full_n    (full_n),
        .rdata     (ring_rdata),
        .pop       (pop),
        .fifo_data (fifo_data),
        .wr_stb    (wr_stb)
    );

    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_INIT) |-> (!wr_stb && !ready));

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (len_q == $past(len_q)));

    // R9
    sent_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sent_q <= len_q));

endmodule

// File: tb/sim_if_capture_streamer.sv
module sim_if_capture_streamer;
    localparam int NB = 13, BB = 2, LW = 8, IC = 8, DEP = NB * BB;
    localparam int NV = 5;
    // fields: len, a, b, full period, full low cycles
    localparam int VEC [NV][5] = '{
        '{6, 1, 0, 0, 0},
        '{13, 3, 1, 5, 2},
        '{20, 2, 3, 3, 1},
        '{1, 1, 2, 0, 0},
        '{40, 1, 1, 7, 6}
    };

    logic clk = 1'b0, rst_n = 1'b0, smp_clk = 1'b0, start = 1'b0, full_n = 1'b1;
    logic [1:0] smp_data = '0;
    logic [LW-1:0] start_len = '0;
    logic [7:0] fifo_data;
    logic [1:0] fifo_addr;
    logic wr_stb, ready, busy, ovf;

    if_capture_streamer #(.NBANK(NB), .BANK_BYTES(BB), .LEN_W(LW), .INIT_CYC(IC)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .smp_data(smp_data),
        .start(start), .start_len(start_len), .full_n(full_n),
        .fifo_data(fifo_data), .fifo_addr(fifo_addr), .wr_stb(wr_stb),
        .ready(ready), .busy(busy), .ovf(ovf));

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int pa = 1, pb = 0, fper = 0, flow = 0;
    bit force_low = 0, mon_on = 0;
    logic [7:0] got [64];
    int got_n = 0, gate_err = 0, addr_err = 0, stab_err = 0;
    logic [7:0] prev_bus = '0;
    logic prev_stb = 0, last_full = 1;

    function automatic logic [1:0] fsmp(int i);
        return 2'((pa * i) + pb * (i >> 2) + (i >> 3));
    endfunction

    function automatic logic [7:0] fbyte(int k);
        return {fsmp(4*k+3), fsmp(4*k+2), fsmp(4*k+1), fsmp(4*k)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        cyc++;
        full_n = force_low ? 1'b0 : ((fper == 0) ? 1'b1 : ((cyc % fper) >= flow));
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    endtask

    task automatic feed_one(int i);
        smp_data = fsmp(i);
        smp_clk = 1'b0;
        repeat (3) tick();
        smp_clk = 1'b1;
        repeat (3) tick();
    endtask

    task automatic do_start(int len);
        start = 1'b1;
        start_len = LW'(len);
        tick();
        start = 1'b0;
        tick();
    endtask

    task automatic wait_ready();
        for (int t = 0; t < 3000 && !ready; t++) tick();
    endtask

    task automatic mon_clear();
        got_n = 0; gate_err = 0; addr_err = 0; stab_err = 0;
        mon_on = 1;
    endtask

    // bridge-side monitor, sampling away from the rising edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_stb) begin
                if (got_n < 64) got[got_n] = fifo_data;
                got_n++;
                if (!last_full) gate_err++;
                if (fifo_addr != 2'b10) addr_err++;
                if (fifo_data != prev_bus) stab_err++;
            end
            if (prev_stb && fifo_data != prev_bus) stab_err++;
        end
        prev_bus = fifo_data;
        prev_stb = wr_stb;
        last_full = full_n;
    end

    initial begin
        repeat (4) tick();
        // R1: reset state and init period
        check(ready == 1'b0 && wr_stb == 1'b0, "R1 reset", int'(ready), 0);
        rst_n = 1'b1;
        tick();
        start = 1'b1; start_len = 8'd3;   // R2: start during init
        tick();
        start = 1'b0;
        repeat (IC - 3) tick();
        check(ready == 1'b0, "R1 still init", int'(ready), 0);
        tick();
        check(ready == 1'b1, "R1 ready after init", int'(ready), 1);
        check(busy == 1'b0, "R2 start during init ignored", int'(busy), 0);

        // table-driven acquisitions
        for (int v = 0; v < NV; v++) begin
            int len;
            len = VEC[v][0]; pa = VEC[v][1]; pb = VEC[v][2];
            fper = VEC[v][3]; flow = VEC[v][4];
            mon_clear();
            do_start(len);
            check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
            for (int i = 0; i < 4*len + 8; i++) begin
                feed_one(i);
                if (v == 1 && i == 8) begin   // R2: start while running
                    start = 1'b1; start_len = 8'd5;
                    tick();
                    start = 1'b0;
                end
            end
            wait_ready();
            repeat (4) tick();
            check(got_n == len, "R9 byte count", got_n, len);
            check(ready == 1'b1 && busy == 1'b0, "R9 back to ready", int'(ready), 1);
            for (int k = 0; k < len && k < 64; k++)
                check(got[k] == fbyte(k), "R3 R5 byte order", int'(got[k]), int'(fbyte(k)));
            check(gate_err == 0, "R6 strobe gated by full_n", gate_err, 0);
            check(stab_err == 0, "R7 data stable around strobe", stab_err, 0);
            check(addr_err == 0, "R8 endpoint address", addr_err, 0);
            check(ovf == 1'b0, "R10 no overflow", int'(ovf), 0);
        end
        fper = 0;

        // R4: stray edges while idle, then a fresh stream from index 0
        pa = 3; pb = 3;
        mon_clear();
        for (int i = 0; i < 5; i++) feed_one(i + 40);
        check(got_n == 0, "R4 idle edges ignored", got_n, 0);
        pa = 1; pb = 0;
        do_start(3);
        for (int i = 0; i < 12; i++) feed_one(i);
        wait_ready();
        repeat (4) tick();
        check(got_n == 3, "R4 count after stray edges", got_n, 3);
        check(got[0] == fbyte(0), "R4 first byte after stray edges", int'(got[0]), int'(fbyte(0)));

        // R9: zero length
        mon_clear();
        do_start(0);
        repeat (3) tick();
        check(ready == 1'b1 && got_n == 0, "R9 zero length", got_n, 0);

        // R10: overflow with bridge held full
        pa = 2; pb = 1;
        mon_clear();
        force_low = 1;
        do_start(40);
        for (int i = 0; i < 120; i++) feed_one(i);
        check(ovf == 1'b1, "R10 overflow set", int'(ovf), 1);
        check(got_n == 0, "R6 no write while full", got_n, 0);
        force_low = 0;
        begin
            int i;
            i = 120;
            while (!ready && i < 1000) begin
                feed_one(i);
                i++;
            end
        end
        repeat (4) tick();
        check(got_n == 40, "R10 count after overflow", got_n, 40);
        for (int k = 0; k < DEP; k++)
            check(got[k] == fbyte(k), "R10 R5 retained bytes", int'(got[k]), int'(fbyte(k)));
        check(ovf == 1'b1, "R10 overflow sticky when idle", int'(ovf), 1);
        mon_clear();
        do_start(1);
        check(ovf == 1'b0, "R10 overflow cleared by start", int'(ovf), 0);
        for (int i = 0; i < 4; i++) feed_one(i);
        wait_ready();

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule